// File: doc/BRIEF.md
# Prescaled JTAG Bit Shifter

This block moves one short burst of up to eight bits across a JTAG port. A controller hands it a data byte, a count of bits minus one, a mode and a prescaler value, then pulses `start`. The shifter sends the bits most-significant first. Each bit has a low phase of TCK in which the outgoing pin settles, followed by a high phase in which the target has captured the bit. TDO is sampled early in the high phase and enters the shift register from the bottom. When the burst ends, the block presents the captured TDO bits and raises `done` for one clock.

Both phase lengths come from one prescaler value P. The low phase lasts (P+1)/2 + 1 clocks and the high phase lasts P/2 + 1 clocks, so one bit takes P+2 clocks. The mode picks which pin carries the data. In one family of modes the data goes out on TDI and TMS is either held low or raised only for the final bit, which is how a scan leaves the shift state. In the other family the data goes out on TMS, for walking the TAP state machine, and TDI is held at a fixed level.

Top module: `prescaled_jtag_shifter`

## Requirements
- R1: After reset, `tck`, `tdi`, `tms`, `busy`, `done` and `tdoByte` are all 0.
- R2: For the prescaler value P latched at start, every TCK low phase lasts (P+1)/2 + 1 clocks and every TCK high phase lasts P/2 + 1 clocks. The first low phase counts from the clock edge that accepts `start`.
- R3: With `mode[1]`=0, TDI carries `dataIn` most-significant bit first, one bit per TCK period. TDI and TMS do not change while TCK is high.
- R4: A transfer produces exactly `bitCount`+1 rising edges of TCK. `done` is high in the cycle that follows the clock edge (`bitCount`+1)*(P+2) edges after the edge that accepted `start`, and `busy` is low in that cycle.
- R5: TDO is sampled one clock after TCK rises. In `tdoByte`, the n = `bitCount`+1 captured bits sit in bits n-1..0, with the first arrival at bit n-1. Bits above n-1 are 0.
- R6: `done` lasts one clock. `tdoByte` keeps its value until the next transfer completes.
- R7: `start` is ignored while `busy` is high. A pulse during a transfer does not begin a second transfer.
- R8: Mode 2'b00 holds TMS low for every bit. Mode 2'b01 drives TMS high for both phases of the last bit only.
- R9: Modes 2'b10 and 2'b11 send `dataIn` on TMS, most-significant bit first, and hold TDI at `mode[0]` for the whole transfer.
- R10: While idle, including the cycle in which `done` is high, `tck`, `tdi` and `tms` are 0.
- R11: `prescale`, `bitCount`, `mode` and `dataIn` are latched when `start` is accepted. Changes to them during a transfer do not affect timing, pin values or the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| dataIn | input | DATA_W | Bits to send, most-significant first |
| bitCount | input | $clog2(DATA_W) | Number of bits minus one |
| prescale | input | PRE_W | Prescaler value P setting the phase lengths |
| mode | input | 2 | bit1: data on TMS; bit0: TMS on last bit, or TDI level in TMS mode |
| tdo | input | 1 | Test data from the target |
| tck | output | 1 | Test clock |
| tdi | output | 1 | Test data to the target |
| tms | output | 1 | Test mode select |
| tdoByte | output | DATA_W | Captured TDO bits, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the shifter with an 8-bit data path and a 3-bit prescaler. This brings every prescaler value from 0 to 7 within a practical sweep, so both the odd and even splits between setup and hold are covered, as is the zero-hold case where sampling and shifting fall in the same clock. Against every prescaler value it sweeps all eight bit counts and all four modes. A bench-side target model measures every phase length, records both pins at each rising edge and feeds a known TDO pattern. In part of the runs, `start` is re-pulsed in the middle of a transfer while the other inputs are scrambled.

// File: rtl/jtag_shift_pkg.sv
package jtag_shift_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HOLD  = 2'd2
  } shiftState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;        // accept a new transfer, latch operands
    logic tckRise;     // end of setup phase, raise TCK
    logic captureTdo;  // first clock of hold phase, sample TDO
    logic shiftStep;   // end of hold phase, shift and drop TCK
    logic useLiveTdo;  // shift in the live TDO pin rather than the stored bit
    logic finish;      // last bit done, publish result
  } pathCtrl_t;

  // mode field bit meanings
  localparam int MODE_ON_TMS_BIT = 1;  // 1: data on TMS, 0: data on TDI
  localparam int MODE_AUX_BIT    = 0;  // last-bit TMS, or TDI level

endpackage

// File: rtl/jtag_shift_ctrl.sv
module jtag_shift_ctrl
  import jtag_shift_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [PRE_W-1:0] prescale,
  input  logic [CNT_W-1:0] bitCount,
  output pathCtrl_t        ctrl,
  output logic             busy,
  output logic             lastBit
);

  shiftState_e      state;
  logic [PRE_W-1:0] phaseCnt;
  logic [PRE_W-1:0] presLat;
  logic [CNT_W-1:0] bitsLeft;
  logic [PRE_W-1:0] setupLen;
  logic [PRE_W-1:0] holdLen;
  logic [PRE_W-1:0] setupOfInput;

  // (p+1)/2 without losing the carry out of p+1
  function automatic logic [PRE_W-1:0] halfUp(input logic [PRE_W-1:0] p);
    logic [PRE_W:0] sum;
    sum = {1'b0, p} + {{PRE_W{1'b0}}, 1'b1};
    return sum[PRE_W:1];
  endfunction

  assign setupLen     = halfUp(presLat);
  assign holdLen      = presLat >> 1;
  assign setupOfInput = halfUp(prescale);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      presLat  <= '0;
      bitsLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            presLat  <= prescale;
            bitsLeft <= bitCount;
            phaseCnt <= setupOfInput;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (phaseCnt == '0) begin
            phaseCnt <= holdLen;
            state    <= ST_HOLD;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (phaseCnt == '0) begin
            if (bitsLeft == '0) begin
              state <= ST_IDLE;
            end else begin
              bitsLeft <= bitsLeft - 1'b1;
              phaseCnt <= setupLen;
              state    <= ST_SETUP;
            end
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl            = '0;
    ctrl.load       = (state == ST_IDLE) && start;
    ctrl.tckRise    = (state == ST_SETUP) && (phaseCnt == '0);
    ctrl.captureTdo = (state == ST_HOLD) && (phaseCnt == holdLen);
    ctrl.useLiveTdo = ctrl.captureTdo;
    ctrl.shiftStep  = (state == ST_HOLD) && (phaseCnt == '0);
    ctrl.finish     = ctrl.shiftStep && (bitsLeft == '0);
  end

  assign busy    = (state != ST_IDLE);
  assign lastBit = busy && (bitsLeft == '0);

endmodule

// File: rtl/jtag_shift_path.sv
module jtag_shift_path
  import jtag_shift_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtrl_t         ctrl,
  input  logic              busy,
  input  logic              lastBit,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic [1:0]        mode,
  input  logic              tdo,
  output logic              tck,
  output logic              tdi,
  output logic              tms,
  output logic [DATA_W-1:0] tdoByte,
  output logic              done
);

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] shiftedNext;
  logic [DATA_W-1:0] lowMask;
  logic [DATA_W-1:0] resultReg;
  logic [CNT_W-1:0]  cntLat;
  logic [1:0]        modeLat;
  logic              tdoBit;
  logic              tckReg;
  logic              doneReg;
  logic              insertBit;
  logic              outBit;

  assign insertBit   = ctrl.useLiveTdo ? tdo : tdoBit;
  assign shiftedNext = {shReg[DATA_W-2:0], insertBit};
  assign outBit      = shReg[DATA_W-1];

  // keep only the bit positions that received TDO
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign lowMask[i] = ((CNT_W+1)'(i) <= {1'b0, cntLat});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      cntLat    <= '0;
      modeLat   <= '0;
      tdoBit    <= 1'b0;
      tckReg    <= 1'b0;
      resultReg <= '0;
      doneReg   <= 1'b0;
    end else begin
      if (ctrl.load) begin
        shReg   <= dataIn;
        cntLat  <= bitCount;
        modeLat <= mode;
      end else if (ctrl.shiftStep) begin
        shReg <= shiftedNext;
      end

      if (ctrl.captureTdo) tdoBit <= tdo;

      if (ctrl.tckRise)        tckReg <= 1'b1;
      else if (ctrl.shiftStep) tckReg <= 1'b0;

      if (ctrl.finish) resultReg <= shiftedNext & lowMask;
      doneReg <= ctrl.finish;
    end
  end

  always_comb begin
    if (modeLat[MODE_ON_TMS_BIT]) begin
      tdi = busy && modeLat[MODE_AUX_BIT];
      tms = busy && outBit;
    end else begin
      tdi = busy && outBit;
      tms = lastBit && modeLat[MODE_AUX_BIT];
    end
  end

  assign tck     = tckReg;
  assign tdoByte = resultReg;
  assign done    = doneReg;

endmodule

// File: rtl/prescaled_jtag_shifter.sv
module prescaled_jtag_shifter
  import jtag_shift_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 4,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [1:0]        mode,
  input  logic              tdo,
  output logic              tck,
  output logic              tdi,
  output logic              tms,
  output logic [DATA_W-1:0] tdoByte,
  output logic              busy,
  output logic              done
);

  pathCtrl_t ctrl;
  logic      lastBit;

  jtag_shift_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .prescale (prescale),
    .bitCount (bitCount),
    .ctrl     (ctrl),
    .busy     (busy),
    .lastBit  (lastBit)
  );

  jtag_shift_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .busy     (busy),
    .lastBit  (lastBit),
    .dataIn   (dataIn),
    .bitCount (bitCount),
    .mode     (mode),
    .tdo      (tdo),
    .tck      (tck),
    .tdi      (tdi),
    .tms      (tms),
    .tdoByte  (tdoByte),
    .done     (done)
  );

endmodule

// File: rtl/prescaled_jtag_shifter_checker.sv
module prescaled_jtag_shifter_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              tck,
  input logic              tdi,
  input logic              tms,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] tdoByte
);

  // pins stay still while TCK is high
  assert_pins_stable_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tck && $past(tck)) |-> ($stable(tdi) && $stable(tms)));

  // completion coincides with the end of busy
  assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // done is a single-cycle pulse
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // result only moves when a transfer completes
  assert_result_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(tdoByte));

  // a transfer begins only from an accepted start
  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // idle pins are quiet
  assert_idle_pins_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!tck && !tdi && !tms));

endmodule

bind prescaled_jtag_shifter prescaled_jtag_shifter_checker #(.DATA_W(DATA_W)) uChecker (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .tck     (tck),
  .tdi     (tdi),
  .tms     (tms),
  .busy    (busy),
  .done    (done),
  .tdoByte (tdoByte)
);

// File: tb/prescaled_jtag_shifter_test.sv
module prescaled_jtag_shifter_test;

  localparam int DW = 8;
  localparam int PW = 3;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [CW-1:0] bitCount = '0;
  logic [PW-1:0] prescale = '0;
  logic [1:0]    mode = '0;
  logic          tdo = 1'b0;
  logic          tck, tdi, tms, busy, done;
  logic [DW-1:0] tdoByte;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  prescaled_jtag_shifter #(.DATA_W(DW), .PRE_W(PW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(dataIn), .bitCount(bitCount),
    .prescale(prescale), .mode(mode), .tdo(tdo), .tck(tck), .tdi(tdi), .tms(tms),
    .tdoByte(tdoByte), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // One transfer with a bench-side target model
  task automatic runXfer(input logic [7:0] d, input int cnt, input int md, input int p,
                         input logic [7:0] pat, input bit disturb);
    int n = cnt + 1;
    int su = (p + 1) / 2;
    int ho = p / 2;
    int k = 0;
    int rises = 0;
    int lowRun = 0;
    int highRun = 0;
    bit prevTck = 0;
    bit tdiRise = 0, tmsRise = 0;
    bit lowOk = 1, highOk = 1, stableOk = 1;
    logic [7:0] gotTdi = '0, gotTms = '0;
    logic [7:0] expData, expOther, expTdo, keepResult;

    @(negedge clk);
    dataIn = d; bitCount = CW'(cnt); mode = 2'(md); prescale = PW'(p);
    tdo = pat[7]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      k++;
      if (disturb && k == 2) begin
        start = 1'b1; dataIn = ~d; bitCount = CW'(cnt ^ 3);
        mode = 2'(md ^ 1); prescale = PW'(p ^ 5);
      end
      if (disturb && k == 3) start = 1'b0;
      if (tck && !prevTck) begin
        rises++;
        if (lowRun != su + 1) lowOk = 0;
        gotTdi = {gotTdi[6:0], tdi};
        gotTms = {gotTms[6:0], tms};
        tdiRise = tdi; tmsRise = tms;
        highRun = 1; lowRun = 0;
      end else if (!tck && prevTck) begin
        if (highRun != ho + 1) highOk = 0;
        lowRun = 1;
        if (rises < 8) tdo = pat[7 - rises];
      end else if (tck) begin
        highRun++;
        if (tdi != tdiRise || tms != tmsRise) stableOk = 0;
      end else begin
        lowRun++;
      end
      prevTck = tck;
      if (done || k > 2000) break;
      @(negedge clk);
    end

    expData = 8'(int'(d) >> (8 - n));
    expTdo  = 8'(int'(pat) >> (8 - n));
    check(k == n * (p + 2) + 1, "R4 done latency", k, n * (p + 2) + 1);
    check(rises == n, "R4 rising edge count", rises, n);
    check(lowOk, "R2 low phase length", lowRun, su + 1);
    check(highOk, "R2 high phase length", highRun, ho + 1);
    check(stableOk, "R3 pins stable while TCK high", 0, 1);
    if (md < 2) begin
      expOther = md[0] ? 8'd1 : 8'd0;
      check(gotTdi == expData, "R3 TDI data MSB first", gotTdi, expData);
      check(gotTms == expOther, "R8 TMS per bit", gotTms, expOther);
    end else begin
      expOther = md[0] ? 8'((1 << n) - 1) : 8'd0;
      check(gotTms == expData, "R9 TMS data MSB first", gotTms, expData);
      check(gotTdi == expOther, "R9 TDI held level", gotTdi, expOther);
    end
    check(tdoByte == expTdo, "R5 captured TDO", tdoByte, expTdo);
    check(!tck && !tdi && !tms && !busy, "R10 idle pins at done",
          {tck, tdi, tms, busy}, 0);
    keepResult = tdoByte;
    @(negedge clk);
    check(!done, "R6 done single cycle", done, 0);
    check(tdoByte == keepResult, "R6 result held", tdoByte, keepResult);
    if (disturb) check(!busy, "R7 start while busy ignored", busy, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!tck && !tdi && !tms && !busy && !done && tdoByte == 0, "R1 reset state",
          {tck, tdi, tms, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !tck, "R10 idle after reset", {busy, tck}, 0);
    check(tdoByte == 0, "R1 result after reset", tdoByte, 0);

    for (int p = 0; p < 8; p++) begin
      for (int cnt = 0; cnt < 8; cnt++) begin
        for (int md = 0; md < 4; md++) begin
          logic [7:0] d, pat;
          d   = 8'(cnt * 37 + p * 11 + md * 73 + 8'h5A);
          pat = 8'(d * 3 + 8'h33) ^ 8'hA5;
          // R11: disturbed runs scramble inputs mid-transfer
          runXfer(d, cnt, md, p, pat, ((p + cnt + md) % 3) == 0);
        end
      end
    end
    // boundary patterns
    runXfer(8'hFF, 7, 0, 1, 8'h00, 1'b1);
    runXfer(8'h00, 7, 1, 0, 8'hFF, 1'b0);
    runXfer(8'h80, 0, 2, 7, 8'h80, 1'b1);
    runXfer(8'h01, 7, 3, 2, 8'h01, 1'b0);
    finishRun();
  end

endmodule